// File: doc/BRIEF.md
# Opcode-Selected Single/Dual/Quad SPI Master

This block is a half-duplex SPI master whose data width and transfer direction are both picked by the command byte that starts each transaction. The caller presents an 8-bit opcode, an address, a byte count and, for writes, a write buffer, then pulses start. The opcode always goes out serially on lane 0, followed by the address on lane 0. The data phase then moves over one, two or four lanes, either driven by the master or, after a turnaround gap in which the master releases every lane, sampled from the device.

The four data lanes are shared in both directions. The master exposes each one as a separate output value, an output-enable and an input value, so the pad ring can build the tri-state pin. The serial clock follows SPI mode 0. The clock idles low, data changes while the clock is low, and the device's data is captured on the rising edge. The half-period is set by a divider input. Each framed transaction is followed by a chip-select-high gap and a one-cycle completion pulse. An opcode outside the supported set is refused. It raises an error flag, and the bus is never touched.

Top module: `qspi_opcode_master`

## Requirements
- R1: The opcode selects the data phase: 0x0B reads on one lane, 0x02 writes on one lane, 0xBB reads on two lanes, 0xB2 writes on two lanes, 0xEB reads on four lanes, 0xE2 writes on four lanes.
- R2: After chip select falls, the 8 opcode bits and then the ADDR_W address bits go out MSB first on lane 0 only, one bit per serial clock, with `dq_oe_o` = 4'b0001.
- R3: In a write data phase, byte 0 (`wdata_i[7:0]`) goes first and each byte is sent MSB first. Each clock carries w bits, and the earliest bit is on lane w-1, so in quad mode lane 3 holds bit 7 and the high nibble precedes the low one. `dq_oe_o` enables exactly lanes w-1..0.
- R4: In a read, after the address the master drives no lane (`dq_oe_o` = 0) for TA_CYC serial clocks, and then for the whole data phase. It samples w lanes per rising edge with the same bit order as R3 and presents the first received byte in `rdata_o[7:0]`. Bytes past the count read as zero.
- R5: Mode 0: `sclk_o` is low whenever chip select is high, and `dq_o`/`dq_oe_o` never change while `sclk_o` is high.
- R6: Each high and each low half of `sclk_o` inside a frame lasts `div_i`+1 clock cycles.
- R7: A start with an opcode outside R1 sets `err_o` from the next cycle on. Chip select, the serial clock, `busy_o` and `done_o` stay idle. `err_o` holds until the next start with a valid opcode is accepted, which clears it.
- R8: Chip select is low from before the first rising edge until after the last falling edge. The frame has exactly 8 + ADDR_W + (read and count > 0 ? TA_CYC : 0) + 8·count/w rising edges.
- R9: After chip select rises it stays high for at least 2·(`div_i`+1) cycles. A start pulse while `busy_o` is high is ignored.
- R10: `done_o` is high for exactly one cycle, the second cycle in which chip select is high after a frame.
- R11: A byte count of 0 ends the frame right after the address, with no turnaround. A count above MAX_BYTES is treated as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial clock half-period minus one, in clk cycles; hold while busy |
| start_i | input | 1 | One-cycle request to begin a transaction |
| opcode_i | input | 8 | Command byte, selects direction and lane count |
| addr_i | input | ADDR_W | Address sent after the opcode |
| len_i | input | LEN_W | Data byte count |
| wdata_i | input | 8·MAX_BYTES | Write bytes, byte 0 in bits 7..0 |
| rdata_o | output | 8·MAX_BYTES | Read bytes, byte 0 in bits 7..0 |
| busy_o | output | 1 | Transaction or post-frame gap in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start carried an unsupported opcode |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| dq_o | output | 4 | Lane output values |
| dq_oe_o | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |

## Verification
All six opcodes are run directly at the fastest divider with a full buffer. This separates lane count and direction, because a wrong lane mapping or nibble order shows up as a mismatch in the data-phase pattern, and a wrong direction shows up in the enables. Zero and oversized counts, unsupported opcodes before and after a good one, and a start pulsed mid-frame check the framing, error and ignore rules. Random transactions over every opcode, count, address and divider follow back to back. They exercise the half-period, the stable-while-high rule and the chip-select gap at different speeds. Read data comes from a bench device model that drives the lanes only from the captured clock count.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {LN_X1 = 2'd0, LN_X2 = 2'd1, LN_X4 = 2'd2} lane_sh_e;

  typedef struct packed {
    logic     valid;
    logic     rd;
    lane_sh_e lsh;
  } op_info_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_TA, ST_DATA, ST_GAP
  } seq_st_e;
endpackage

// File: rtl/qspi_op_decode.sv
module qspi_op_decode
  import qspi_pkg::*;
(
  input  logic [7:0] opcode_i,
  output op_info_t   info_o
);
  always_comb begin
    info_o = '{valid: 1'b0, rd: 1'b0, lsh: LN_X1};
    unique case (opcode_i)
      8'h0B: info_o = '{valid: 1'b1, rd: 1'b1, lsh: LN_X1};
      8'h02: info_o = '{valid: 1'b1, rd: 1'b0, lsh: LN_X1};
      8'hBB: info_o = '{valid: 1'b1, rd: 1'b1, lsh: LN_X2};
      8'hB2: info_o = '{valid: 1'b1, rd: 1'b0, lsh: LN_X2};
      8'hEB: info_o = '{valid: 1'b1, rd: 1'b1, lsh: LN_X4};
      8'hE2: info_o = '{valid: 1'b1, rd: 1'b0, lsh: LN_X4};
      default: ;
    endcase
  end
endmodule

// File: rtl/qspi_tick_gen.sv
module qspi_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_BYTES = 4,
  parameter int TA_CYC    = 2,
  parameter int LEN_W     = 3,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int SR_W     = 8 + ADDR_W + DATA_W,
  localparam int CNT_W    = $clog2(SR_W + TA_CYC + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  op_info_t          info_i,
  input  logic              tick_i,
  input  logic [3:0]        dq_i,
  output logic              run_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  output logic [DATA_W-1:0] rx_o,
  output logic [LEN_W-1:0]  len_o
);
  seq_st_e           state_q;
  logic              rd_q;
  lane_sh_e          lsh_q;
  logic [SR_W-1:0]   sr_q;
  logic [DATA_W-1:0] rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              sclk_q, cs_n_q, done_q, gap_first_q, err_q;

  logic [DATA_W-1:0] wswap;
  logic [LEN_W-1:0]  len_sat;
  logic [CNT_W-1:0]  data_clks;
  logic [2:0]        w_amt;
  logic [3:0]        rx_bits;

  // byte 0 leads on the wire, so it sits at the top of the shifter
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_swap
    assign wswap[(MAX_BYTES-1-i)*8 +: 8] = wdata_i[i*8 +: 8];
  end

  assign len_sat   = (int'(len_i) > MAX_BYTES) ? LEN_W'(MAX_BYTES) : len_i;
  assign data_clks = CNT_W'({len_q, 3'b000} >> lsh_q);
  assign w_amt     = 3'd1 << lsh_q;

  always_comb begin
    unique case (lsh_q)
      LN_X1:   rx_bits = {3'b000, dq_i[0]};
      LN_X2:   rx_bits = {2'b00, dq_i[1:0]};
      default: rx_bits = dq_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rd_q        <= 1'b0;
      lsh_q       <= LN_X1;
      sr_q        <= '0;
      rx_q        <= '0;
      cnt_q       <= '0;
      len_q       <= '0;
      sclk_q      <= 1'b0;
      cs_n_q      <= 1'b1;
      done_q      <= 1'b0;
      gap_first_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q      <= gap_first_q;
      gap_first_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (info_i.valid) begin
            state_q <= ST_OPC;
            rd_q    <= info_i.rd;
            lsh_q   <= info_i.lsh;
            sr_q    <= {opcode_i, addr_i, wswap};
            rx_q    <= '0;
            len_q   <= len_sat;
            cnt_q   <= CNT_W'(8);
            cs_n_q  <= 1'b0;
            err_q   <= 1'b0;
          end else begin
            err_q   <= 1'b1;
          end
        end
        ST_GAP: if (tick_i) begin
          if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
          else                    cnt_q   <= cnt_q - 1'b1;
        end
        default: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (state_q == ST_DATA && rd_q)
              rx_q <= (rx_q << w_amt) | DATA_W'(rx_bits);
          end else begin
            sclk_q <= 1'b0;
            if (state_q == ST_OPC || state_q == ST_ADDR) sr_q <= sr_q << 1;
            else if (state_q == ST_DATA && !rd_q)       sr_q <= sr_q << w_amt;
            if (cnt_q != CNT_W'(1)) begin
              cnt_q <= cnt_q - 1'b1;
            end else begin
              unique case (state_q)
                ST_OPC: begin
                  state_q <= ST_ADDR;
                  cnt_q   <= CNT_W'(ADDR_W);
                end
                ST_ADDR: begin
                  if (len_q == '0) begin
                    state_q <= ST_GAP; cs_n_q <= 1'b1; cnt_q <= CNT_W'(2); gap_first_q <= 1'b1;
                  end else if (rd_q && TA_CYC != 0) begin
                    state_q <= ST_TA;   cnt_q <= CNT_W'(TA_CYC);
                  end else begin
                    state_q <= ST_DATA; cnt_q <= data_clks;
                  end
                end
                ST_TA: begin
                  state_q <= ST_DATA;
                  cnt_q   <= data_clks;
                end
                default: begin
                  state_q <= ST_GAP; cs_n_q <= 1'b1; cnt_q <= CNT_W'(2); gap_first_q <= 1'b1;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    dq_o    = '0;
    dq_oe_o = '0;
    if (state_q == ST_OPC || state_q == ST_ADDR) begin
      dq_o[0] = sr_q[SR_W-1];
      dq_oe_o = 4'b0001;
    end else if (state_q == ST_DATA && !rd_q) begin
      unique case (lsh_q)
        LN_X1:   begin dq_o[0]   = sr_q[SR_W-1];       dq_oe_o = 4'b0001; end
        LN_X2:   begin dq_o[1:0] = sr_q[SR_W-1 -: 2];  dq_oe_o = 4'b0011; end
        default: begin dq_o      = sr_q[SR_W-1 -: 4];  dq_oe_o = 4'b1111; end
      endcase
    end
  end

  assign run_o  = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign sclk_o = sclk_q;
  assign cs_no  = cs_n_q;
  assign rx_o   = rx_q;
  assign len_o  = len_q;
endmodule

// File: rtl/qspi_opcode_master.sv
module qspi_opcode_master
  import qspi_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_BYTES = 4,
  parameter int TA_CYC    = 2,
  parameter int DIV_W     = 4,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = MAX_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  input  logic [3:0]        dq_i
);
  op_info_t          op_info;
  logic              run, tick;
  logic [DATA_W-1:0] rx;
  logic [LEN_W-1:0]  len_q;

  qspi_op_decode u_dec (
    .opcode_i (opcode_i),
    .info_o   (op_info)
  );

  qspi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .div_i  (div_i),
    .tick_o (tick)
  );

  qspi_seq #(
    .ADDR_W    (ADDR_W),
    .MAX_BYTES (MAX_BYTES),
    .TA_CYC    (TA_CYC),
    .LEN_W     (LEN_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .addr_i   (addr_i),
    .len_i    (len_i),
    .wdata_i  (wdata_i),
    .info_i   (op_info),
    .tick_i   (tick),
    .dq_i     (dq_i),
    .run_o    (run),
    .done_o   (done_o),
    .err_o    (err_o),
    .sclk_o   (sclk_o),
    .cs_no    (cs_no),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o),
    .rx_o     (rx),
    .len_o    (len_q)
  );

  // first received byte ends up highest in rx; flip to byte-0-low order
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < MAX_BYTES; i++)
      if (i < int'(len_q)) rdata_o[i*8 +: 8] = rx[(int'(len_q) - 1 - i)*8 +: 8];
  end

  assign busy_o = run;
endmodule

// File: rtl/qspi_opcode_master_chk.sv
module qspi_opcode_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_no,
  input logic       sclk_o,
  input logic [3:0] dq_o,
  input logic [3:0] dq_oe_o,
  input logic       done_o,
  input logic       err_o,
  input logic       busy_o
);
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R5

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> ($stable(dq_o) && $stable(dq_oe_o))); // R5

  AST_NO_DRIVE_UNFRAMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (dq_oe_o == 4'b0000)); // R8

  AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o inside {4'b0000, 4'b0001, 4'b0011, 4'b1111}); // R3

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(cs_no))); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (cs_no && !busy_o)); // R7
endmodule

bind qspi_opcode_master qspi_opcode_master_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .busy_o  (busy_o)
);

// File: tb/qspi_opcode_master_bench.sv
module qspi_opcode_master_bench;
  localparam int ADDR_W = 24, MAX_BYTES = 4, TA_CYC = 2, DIV_W = 4, LEN_W = 3;
  localparam int PRE = 8 + ADDR_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div = '0;
  logic              start = 1'b0;
  logic [7:0]        opcode = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              busy, done, err, sclk, cs_n;
  logic [3:0]        dq_o, dq_oe, dq_i = 4'hA;

  qspi_opcode_master u_qspi_opcode_master (
    .clk_i (clk), .rst_ni (rst_n), .div_i (div), .start_i (start),
    .opcode_i (opcode), .addr_i (addr), .len_i (len), .wdata_i (wdata),
    .rdata_o (rdata), .busy_o (busy), .done_o (done), .err_o (err),
    .sclk_o (sclk), .cs_no (cs_n), .dq_o (dq_o), .dq_oe_o (dq_oe), .dq_i (dq_i)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int hi_cnt = 0, last_gap = 0, prev_div = 0;
  bit have_prev = 0;
  logic [3:0] cap_dq [0:127];
  logic [3:0] cap_oe [0:127];

  always @(negedge clk) begin
    if (cs_n) hi_cnt++;
    else begin if (hi_cnt > 0) last_gap = hi_cnt; hi_cnt = 0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void op_kind(input logic [7:0] op, output bit ok, output bit rd, output int w);
    ok = 1; rd = 0; w = 1;
    case (op)
      8'h0B: begin rd = 1; w = 1; end
      8'h02: begin rd = 0; w = 1; end
      8'hBB: begin rd = 1; w = 2; end
      8'hB2: begin rd = 0; w = 2; end
      8'hEB: begin rd = 1; w = 4; end
      8'hE2: begin rd = 0; w = 4; end
      default: ok = 0;
    endcase
  endfunction

  function automatic logic stream_bit(input logic [31:0] b, input int s);
    return b[(s/8)*8 + 7 - (s%8)];
  endfunction

  function automatic logic [3:0] lane_val(input logic [31:0] b, input int k, input int w);
    logic [3:0] v = '0;
    for (int j = 0; j < w; j++) v[w-1-j] = stream_bit(b, k*w + j);
    return v;
  endfunction

  task automatic run_txn(input logic [7:0] op, input logic [ADDR_W-1:0] a, input int n,
                         input int dv, input logic [31:0] wd, input logic [31:0] rb,
                         input bit inject);
    bit ok, rd; int w, nb, nclk, ta, exp_rises, rises, hi_run, per_err, stab_err, errs;
    bit prev_s, prev_c, done_seen, done_ok, err_bad;
    logic [3:0] mask;
    op_kind(op, ok, rd, w);
    nb = (n > MAX_BYTES) ? MAX_BYTES : n;
    nclk = nb * 8 / w;
    ta = (rd && nb > 0) ? TA_CYC : 0;
    exp_rises = PRE + ta + nclk;
    mask = (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
    while (busy) @(negedge clk);
    opcode = op; addr = a; len = LEN_W'(n); div = DIV_W'(dv); wdata = wd; start = 1'b1;
    dq_i = 4'hA;
    @(negedge clk); start = 1'b0;
    rises = 0; hi_run = 0; per_err = 0; stab_err = 0; errs = 0;
    prev_s = 0; prev_c = 0; done_seen = 0; done_ok = 0; err_bad = 0;
    for (int t = 0; t < 8000 && !done_seen; t++) begin
      if (t > 0) @(negedge clk);
      if (start) start = 1'b0;
      if (err) err_bad = 1;
      if (done) begin done_seen = 1; done_ok = cs_n && prev_c; end
      if (!cs_n && sclk && !prev_s) begin
        if (rises < 128) begin cap_dq[rises] = dq_o; cap_oe[rises] = dq_oe; end
        rises++; hi_run = 1;
      end else if (sclk && prev_s) begin
        hi_run++;
        if (rises > 0 && rises <= 128 && (dq_o !== cap_dq[rises-1] || dq_oe !== cap_oe[rises-1]))
          stab_err++;
      end
      if (!sclk && prev_s && hi_run != dv + 1) per_err++;
      if (rd && rises >= PRE + ta && rises < exp_rises) dq_i = lane_val(rb, rises - PRE - ta, w);
      else dq_i = 4'hA;
      if (inject && rises == 10 && !cs_n) begin opcode = 8'h00; start = 1'b1; end
      prev_s = sclk; prev_c = cs_n;
    end
    chk(done_seen && done_ok, "R10", "done pulse after chip select release", done_ok, 1);
    chk(rises == exp_rises, "R8", "rising edges in frame", rises, exp_rises);
    errs = 0;
    for (int k = 0; k < PRE && k < rises; k++) begin
      logic b;
      b = (k < 8) ? op[7-k] : a[ADDR_W-1-(k-8)];
      if (cap_dq[k] !== {3'b000, b} || cap_oe[k] !== 4'b0001) errs++;
    end
    chk(errs == 0, "R2", "opcode/address bits on lane 0", errs, 0);
    errs = 0;
    for (int k = PRE; k < exp_rises && k < rises; k++) begin
      if (rd) begin
        if (cap_oe[k] !== 4'b0000) errs++;
      end else if (cap_oe[k] !== mask || cap_dq[k] !== lane_val(wd, k - PRE, w)) errs++;
    end
    if (nb > 0) chk(errs == 0, "R1", $sformatf("data phase of opcode %0h", op), errs, 0);
    if (rd) begin
      logic [31:0] exp_r;
      exp_r = (nb == 4) ? rb : (rb & ((32'h1 << (8*nb)) - 1));
      chk(rdata === exp_r, "R4", "read data", rdata, exp_r);
    end else if (nb > 0) begin
      chk(errs == 0, "R3", "write lane pattern", errs, 0);
    end
    chk(per_err == 0, "R6", "sclk high half length", per_err, 0);
    chk(stab_err == 0, "R5", "lanes stable while sclk high", stab_err, 0);
    if (inject) chk(!err_bad, "R9", "start during busy ignored", err_bad, 0);
    if (have_prev) chk(last_gap >= 2*(prev_div+1), "R9", "chip select gap", last_gap, 2*(prev_div+1));
    have_prev = 1; prev_div = dv;
  endtask

  task automatic bad_op(input logic [7:0] op);
    bit quiet;
    while (busy) @(negedge clk);
    opcode = op; start = 1'b1;
    @(negedge clk); start = 1'b0;
    quiet = 1;
    chk(err === 1'b1, "R7", "error flag on unsupported opcode", err, 1);
    for (int t = 0; t < 12; t++) begin
      if (!cs_n || sclk || busy || done) quiet = 0;
      @(negedge clk);
    end
    chk(quiet && err === 1'b1, "R7", "bus idle and flag held", {quiet, err}, 2'b11);
    have_prev = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    ops = '{8'h0B, 8'h02, 8'hBB, 8'hB2, 8'hEB, 8'hE2};
    void'($urandom(32'h51A7));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && dq_oe === 4'h0, "R5", "reset bus state",
        {cs_n, sclk, dq_oe}, 6'b100000);
    chk(done === 1'b0 && err === 1'b0 && busy === 1'b0, "R10", "reset flags", {done, err, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (ops[i]) run_txn(ops[i], 24'hA5C31E, 4, 0, 32'h3C96_E15A, 32'h81F0_7E2D, 0);
    run_txn(8'h02, 24'h000001, 0, 1, 32'hFFFF_FFFF, 32'h0, 0);  // R11 empty write
    run_txn(8'hEB, 24'hFFFFFF, 0, 2, 32'h0, 32'hDEAD_BEEF, 0);  // R11 empty read, no turnaround
    run_txn(8'hE2, 24'h123456, 7, 0, 32'hCAFE_1234, 32'h0, 0);  // R11 oversized count
    run_txn(8'hBB, 24'h0F0F0F, 7, 1, 32'h0, 32'h5AA5_C33C, 0);  // R11 oversized read
    bad_op(8'h03);
    bad_op(8'hFF);
    run_txn(8'h0B, 24'h55AA55, 2, 3, 32'h0, 32'h0000_9D61, 0);
    chk(err === 1'b0, "R7", "flag cleared by accepted start", err, 0);
    run_txn(8'hB2, 24'h654321, 3, 1, 32'h00A1_B2C3, 32'h0, 1);  // R9 mid-frame start
    for (int i = 0; i < 40; i++)
      run_txn(ops[$urandom_range(0, 5)], ADDR_W'($urandom), $urandom_range(0, 4),
              $urandom_range(0, 3), $urandom, $urandom, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule